// File: doc/BRIEF.md
# Indexed Operand Bus Sequencer

This block produces the bus cycles an 8-bit processor core with a 16-bit address space spends to reach an indexed memory operand. The core's decoder gives it an access kind (read, write or read-modify-write), an addressing form, a base address or zero-page pointer, an index byte, the current program counter and a core-variant select. It then runs one bus cycle per clock. In each cycle it drives the address, the read/write strobe and the write data. A done pulse marks the final data cycle.

The sequence depends on the addressing form, the access kind and the variant. An absolute-indexed read that stays within the base page goes straight to the operand. A read that crosses into the next page first spends a fix-up cycle. Writes and read-modify-writes always spend the fix-up cycle. The address of that fix-up cycle depends on the variant. In the read-modify-write stall cycle, the original variant writes the unmodified value back, while the enhanced variant reads. The pointer form first fetches a 16-bit pointer from page zero. The zero-page indexed form wraps inside page zero. The ALU result for a write cycle arrives on `new_val_i` in the cycle it is written.

Top module: `idx_bus_seq`

## Requirements
- R1: While reset is active, and whenever no sequence runs, `busy_o` is 0, `rw_o` is 1 (1 = read, 0 = write), `done_o` is 0 and `addr_o` is 0.
- R2: A `start_i` pulse while idle latches the request, and the first bus cycle appears in the next clock cycle. For an absolute-indexed read (`kind_i`=0, `mode_i`=0) whose low-byte sum of base and index does not carry, the sequence is a single read at base+index.
- R3: For an absolute-indexed read whose low-byte sum carries, a fix-up read comes first, followed by the operand read at base+index (16-bit sum).
- R4: A write (`kind_i`=1) or read-modify-write (`kind_i`=2) in absolute-indexed or pointer form always spends the fix-up cycle, whether or not the page is crossed.
- R5: With `enh_i`=0, the fix-up cycle reads address {base high byte, low byte of base+index}.
- R6: With `enh_i`=1, the fix-up cycle reads at the latched `pc_i`.
- R7: A read-modify-write reads the operand at the effective address, then runs a stall cycle there, then writes `new_val_i` there. In the stall cycle the original variant writes back the value that was read, and the enhanced variant reads. A plain write drives `new_val_i` on its single write cycle.
- R8: In pointer form (`mode_i`=1), the block first reads the pointer low byte at {0x00, p} and then the high byte at {0x00, (p+1) mod 256}, where p is the low byte of `base_i`. The pointer plus the index then follows R2 to R5.
- R9: In zero-page indexed form (`mode_i`=2), the block makes a dummy read at {0x00, base low byte}. It then accesses {0x00, (base low + index) mod 256} with no fix-up cycle. Every address in this form has a zero high byte.
- R10: With `enh_i`=1 and `dec_i`=1, a read adds one more read at the effective address after the operand read. The flag has no effect with `enh_i`=0 or on writes and read-modify-writes.
- R11: `done_o` is high for exactly the final cycle of a sequence. On reads and read-modify-writes, `rd_data_o` on that cycle equals the operand read. `start_i` is ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a sequence (sampled while idle) |
| kind_i | input | 2 | 0 read, 1 write, 2 read-modify-write |
| mode_i | input | 2 | 0 absolute indexed, 1 pointer indexed, 2 zero-page indexed |
| enh_i | input | 1 | 0 original variant, 1 enhanced variant |
| dec_i | input | 1 | Decimal-mode add/subtract request |
| base_i | input | 16 | Base address, or zero-page pointer/base in its low byte |
| idx_i | input | 8 | Index value |
| pc_i | input | 16 | Program counter, used for the enhanced fix-up cycle |
| new_val_i | input | 8 | Value written on the final write cycle |
| rdata_i | input | 8 | Bus read data for the current cycle |
| addr_o | output | 16 | Bus address |
| rw_o | output | 1 | 1 read, 0 write |
| wdata_o | output | 8 | Bus write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final data cycle |
| rd_data_o | output | 8 | Operand value, valid with done_o |

## Verification
The bench builds the block with its default widths: a 16-bit address and an 8-bit data and index path. With these widths, the page boundary, the page-zero pointer wrap at 0xFF and the index carry out of the low byte can all be reached with ordinary byte stimulus. The bench models memory as a fixed function of the address. This lets it predict every pointer byte and operand byte and compare each bus cycle against a sequence rebuilt from the requirements. Both variants and all three access kinds are covered, including the decimal extra cycle.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_RMW = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    AM_ABS = 2'd0,
    AM_PTR = 2'd1,
    AM_ZPX = 2'd2
  } addr_form_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_ZP_DUMMY,
    ST_FIX,
    ST_OP_RD,
    ST_DEC_RD,
    ST_STALL,
    ST_OP_WR
  } seq_state_e;

endpackage

// File: rtl/idx_addr_calc.sv
module idx_addr_calc #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] idx_i,
  input  logic          zp_wrap_i,
  output logic [AW-1:0] eff_o,
  output logic [AW-1:0] unfix_o,
  output logic          cross_o
);
  localparam int HW = AW - DW;

  logic [DW:0]   lo_sum;
  logic [HW-1:0] hi_base;
  logic [HW-1:0] hi_fixed;

  always_comb begin
    lo_sum   = {1'b0, base_i[DW-1:0]} + {1'b0, idx_i};
    hi_base  = base_i[AW-1:DW];
    hi_fixed = hi_base + {{(HW-1){1'b0}}, lo_sum[DW]};
    if (zp_wrap_i) begin
      eff_o   = {{HW{1'b0}}, lo_sum[DW-1:0]};
      unfix_o = {{HW{1'b0}}, lo_sum[DW-1:0]};
      cross_o = 1'b0;
    end else begin
      eff_o   = {hi_fixed, lo_sum[DW-1:0]};
      unfix_o = {hi_base, lo_sum[DW-1:0]};
      cross_o = lo_sum[DW];
    end
  end
endmodule

// File: rtl/idx_bus_drive.sv
module idx_bus_drive
  import idx_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  seq_state_e    state_i,
  input  logic          enh_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] unfix_i,
  input  logic [AW-1:0] eff_i,
  input  logic [DW-1:0] op_i,
  input  logic [DW-1:0] new_val_i,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic [DW-1:0] wdata_o
);
  localparam int HW = AW - DW;

  logic [DW-1:0] ptr_next;

  always_comb begin
    ptr_next = base_i[DW-1:0] + {{(DW-1){1'b0}}, 1'b1};
    addr_o   = '0;
    rw_o     = 1'b1;
    wdata_o  = '0;
    unique case (state_i)
      ST_PTR_LO, ST_ZP_DUMMY: addr_o = {{HW{1'b0}}, base_i[DW-1:0]};
      ST_PTR_HI:              addr_o = {{HW{1'b0}}, ptr_next};
      ST_FIX:                 addr_o = enh_i ? pc_i : unfix_i;
      ST_OP_RD, ST_DEC_RD:    addr_o = eff_i;
      ST_STALL: begin
        addr_o = eff_i;
        rw_o   = enh_i;
        if (!enh_i) wdata_o = op_i;
      end
      ST_OP_WR: begin
        addr_o  = eff_i;
        rw_o    = 1'b0;
        wdata_o = new_val_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idx_bus_seq.sv
module idx_bus_seq
  import idx_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    kind_i,
  input  logic [1:0]    mode_i,
  input  logic          enh_i,
  input  logic          dec_i,
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] idx_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] new_val_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int HW = AW - DW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  seq_state_e    state_q, state_d;
  logic [1:0]    kind_q, mode_q;
  logic          enh_q, dec_q;
  logic [AW-1:0] base_q, pc_q, eff_q, unfix_q;
  logic [DW-1:0] idx_q, ptr_lo_q, op_q;

  logic          ld_req, ld_eff, ld_ptr, ld_op;
  logic [1:0]    cur_kind, cur_mode;
  logic [AW-1:0] calc_base, calc_eff, calc_unfix;
  logic [DW-1:0] calc_idx;
  logic          calc_cross, calc_zp;
  logic          k_wr, k_rmw, k_rd, extra_dec;

  always_comb begin
    cur_kind  = (state_q == ST_IDLE) ? kind_i : kind_q;
    cur_mode  = (state_q == ST_IDLE) ? mode_i : mode_q;
    k_wr      = (cur_kind == ACC_WR);
    k_rmw     = (cur_kind == ACC_RMW);
    k_rd      = !k_wr && !k_rmw;
    extra_dec = enh_q && dec_q && k_rd;
    calc_zp   = (cur_mode == AM_ZPX);
    calc_idx  = (state_q == ST_IDLE) ? idx_i : idx_q;
    if (state_q == ST_PTR_HI)     calc_base = {rdata_i, ptr_lo_q};
    else if (state_q == ST_IDLE)  calc_base = base_i;
    else                          calc_base = base_q;
  end

  idx_addr_calc #(.AW(AW), .DW(DW)) u_calc (
    .base_i    (calc_base),
    .idx_i     (calc_idx),
    .zp_wrap_i (calc_zp),
    .eff_o     (calc_eff),
    .unfix_o   (calc_unfix),
    .cross_o   (calc_cross)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    ld_req  = 1'b0;
    ld_eff  = 1'b0;
    ld_ptr  = 1'b0;
    ld_op   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        ld_req = 1'b1;
        if (cur_mode == AM_PTR)      state_d = ST_PTR_LO;
        else if (cur_mode == AM_ZPX) state_d = ST_ZP_DUMMY;
        else begin
          ld_eff  = 1'b1;
          state_d = (k_rd && !calc_cross) ? ST_OP_RD : ST_FIX;
        end
      end
      ST_PTR_LO: begin
        ld_ptr  = 1'b1;
        state_d = ST_PTR_HI;
      end
      ST_PTR_HI: begin
        ld_eff  = 1'b1;
        state_d = (k_rd && !calc_cross) ? ST_OP_RD : ST_FIX;
      end
      ST_ZP_DUMMY: begin
        ld_eff  = 1'b1;
        state_d = k_wr ? ST_OP_WR : ST_OP_RD;
      end
      ST_FIX:   state_d = k_wr ? ST_OP_WR : ST_OP_RD;
      ST_OP_RD: begin
        ld_op = 1'b1;
        if (k_rmw)          state_d = ST_STALL;
        else if (extra_dec) state_d = ST_DEC_RD;
        else                state_d = ST_IDLE;
      end
      ST_DEC_RD: state_d = ST_IDLE;
      ST_STALL:  state_d = ST_OP_WR;
      ST_OP_WR:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_q   <= '0;
      mode_q   <= '0;
      enh_q    <= 1'b0;
      dec_q    <= 1'b0;
      base_q   <= '0;
      pc_q     <= '0;
      idx_q    <= '0;
      eff_q    <= '0;
      unfix_q  <= '0;
      ptr_lo_q <= '0;
      op_q     <= '0;
    end else begin
      state_q <= state_d;
      if (ld_req) begin
        kind_q <= kind_i;
        mode_q <= mode_i;
        enh_q  <= enh_i;
        dec_q  <= dec_i;
        base_q <= base_i;
        pc_q   <= pc_i;
        idx_q  <= idx_i;
      end
      if (ld_eff) begin
        eff_q   <= calc_eff;
        unfix_q <= calc_unfix;
      end
      if (ld_ptr) ptr_lo_q <= rdata_i;
      if (ld_op)  op_q     <= rdata_i;
    end
  end

  idx_bus_drive #(.AW(AW), .DW(DW)) u_drive (
    .state_i   (state_q),
    .enh_i     (enh_q),
    .base_i    (base_q),
    .pc_i      (pc_q),
    .unfix_i   (unfix_q),
    .eff_i     (eff_q),
    .op_i      (op_q),
    .new_val_i (new_val_i),
    .addr_o    (addr_o),
    .rw_o      (rw_o),
    .wdata_o   (wdata_o)
  );

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DEC_RD) || (state_q == ST_OP_WR) ||
                     ((state_q == ST_OP_RD) && k_rd && !extra_dec);
  assign rd_data_o = ((state_q == ST_OP_RD) || (state_q == ST_DEC_RD)) ? rdata_i : op_q;

  // R1
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_o |-> (rw_o && !done_o));

  // R11
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R7
  stall_writeback_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_STALL && !enh_q) |-> (!rw_o && wdata_o == $past(rdata_i)));

  // R8
  ptr_hi_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_PTR_HI) |->
      (addr_o[AW-1:DW] == '0 && addr_o[DW-1:0] == $past(addr_o[DW-1:0]) + 1'b1));

  // R5
  fix_low_kept_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_FIX && !enh_q) |=> (addr_o[DW-1:0] == $past(addr_o[DW-1:0])));

  // R9
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && mode_q == AM_ZPX) |-> (addr_o[AW-1:DW] == '0));

endmodule

// File: tb/idx_bus_seq_tb.sv
module idx_bus_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  kind, mode;
  logic        enh, dec;
  logic [15:0] base, pc;
  logic [7:0]  idx, new_val;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic        rw, busy, done;
  logic [7:0]  wdata, rd_data;

  int checks = 0;
  int fails  = 0;

  logic [15:0] ex_a [0:7];
  logic        ex_rw[0:7];
  logic [7:0]  ex_wd[0:7];
  int          ex_n;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign rdata = memf(addr);

  idx_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind), .mode_i(mode),
    .enh_i(enh), .dec_i(dec), .base_i(base), .idx_i(idx), .pc_i(pc),
    .new_val_i(new_val), .rdata_i(rdata), .addr_o(addr), .rw_o(rw),
    .wdata_o(wdata), .busy_o(busy), .done_o(done), .rd_data_o(rd_data)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic r, input logic [7:0] d);
    ex_a[ex_n] = a; ex_rw[ex_n] = r; ex_wd[ex_n] = d; ex_n++;
  endtask

  // expected sequence rebuilt from the requirements
  task automatic build(input logic [1:0] k, input logic [1:0] m, input logic e, input logic dc,
                       input logic [15:0] b, input logic [7:0] ix, input logic [15:0] p,
                       input logic [7:0] nv, output logic [15:0] eff);
    logic [15:0] bb, sum;
    logic [7:0]  p1;
    ex_n = 0;
    if (m == 2'd2) begin
      push({8'h00, b[7:0]}, 1'b1, 8'h00);
      eff = {8'h00, b[7:0] + ix};
    end else begin
      bb = b;
      if (m == 2'd1) begin
        p1 = b[7:0] + 8'd1;
        push({8'h00, b[7:0]}, 1'b1, 8'h00);
        push({8'h00, p1}, 1'b1, 8'h00);
        bb = {memf({8'h00, p1}), memf({8'h00, b[7:0]})};
      end
      sum = bb + {8'h00, ix};
      if (k != 2'd0 || sum[15:8] != bb[15:8])
        push(e ? p : {bb[15:8], sum[7:0]}, 1'b1, 8'h00);
      eff = sum;
    end
    if (k == 2'd1) push(eff, 1'b0, nv);
    else if (k == 2'd2) begin
      push(eff, 1'b1, 8'h00);
      push(eff, e, e ? 8'h00 : memf(eff));
      push(eff, 1'b0, nv);
    end else begin
      push(eff, 1'b1, 8'h00);
      if (e && dc) push(eff, 1'b1, 8'h00);
    end
  endtask

  task automatic run_op(input string tag, input logic [1:0] k, input logic [1:0] m,
                        input logic e, input logic dc, input logic [15:0] b,
                        input logic [7:0] ix, input logic [15:0] p);
    logic [15:0] eff;
    logic [7:0]  nv;
    nv = 8'($urandom);
    build(k, m, e, dc, b, ix, p, nv, eff);
    @(negedge clk);
    kind = k; mode = m; enh = e; dec = dc; base = b; idx = ix; pc = p; new_val = nv;
    start = 1'b1;
    for (int i = 0; i < ex_n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        // R11: a second start while busy carries junk and must be ignored
        start = 1'b1; base = ~b; idx = ~ix; pc = ~p; kind = ~k; mode = 2'd0; enh = ~e;
      end else start = 1'b0;
      chk(tag, $sformatf("cycle %0d addr", i), 32'(addr), 32'(ex_a[i]));
      chk(tag, $sformatf("cycle %0d rw", i), 32'(rw), 32'(ex_rw[i]));
      if (!ex_rw[i]) chk(tag, $sformatf("cycle %0d wdata", i), 32'(wdata), 32'(ex_wd[i]));
      chk("R11", $sformatf("%s cycle %0d done", tag, i), 32'(done), 32'(i == ex_n - 1));
      if (i == ex_n - 1 && k != 2'd1)
        chk("R11", {tag, " rd_data"}, 32'(rd_data), 32'(memf(eff)));
    end
    start = 1'b0;
    @(negedge clk);
    chk("R1", {tag, " idle after done"}, 32'({busy, rw, done}), 32'(3'b010));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0; start = 1'b0; kind = '0; mode = '0; enh = 1'b0; dec = 1'b0;
    base = '0; idx = '0; pc = '0; new_val = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", 32'({busy, rw, done, addr}), 32'({3'b010, 16'h0000}));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle outputs", 32'({busy, rw, done, addr}), 32'({3'b010, 16'h0000}));

    run_op("R2 read no carry",       2'd0, 2'd0, 1'b0, 1'b0, 16'h1230, 8'h0F, 16'h8000);
    run_op("R3 R5 read carry orig",  2'd0, 2'd0, 1'b0, 1'b0, 16'h12F0, 8'h20, 16'h8000);
    run_op("R3 R6 read carry enh",   2'd0, 2'd0, 1'b1, 1'b0, 16'h12F0, 8'h20, 16'h8004);
    run_op("R4 R5 write no carry",   2'd1, 2'd0, 1'b0, 1'b0, 16'h4000, 8'h05, 16'h9000);
    run_op("R4 R6 write enh",        2'd1, 2'd0, 1'b1, 1'b0, 16'h40FF, 8'h01, 16'h9002);
    run_op("R7 rmw orig",            2'd2, 2'd0, 1'b0, 1'b0, 16'h5510, 8'h03, 16'hA000);
    run_op("R7 rmw enh carry",       2'd2, 2'd0, 1'b1, 1'b0, 16'h55FE, 8'h04, 16'hA010);
    run_op("R7 write wraps 64k",     2'd1, 2'd0, 1'b0, 1'b0, 16'hFFF0, 8'h20, 16'h0100);
    run_op("R8 ptr wrap at FF",      2'd0, 2'd1, 1'b0, 1'b0, 16'h00FF, 8'h01, 16'hB000);
    run_op("R8 ptr carry orig",      2'd0, 2'd1, 1'b0, 1'b0, 16'h0040, 8'hFF, 16'hB000);
    run_op("R8 ptr rmw enh",         2'd2, 2'd1, 1'b1, 1'b0, 16'h0080, 8'h10, 16'hB100);
    run_op("R9 zp wrap read",        2'd0, 2'd2, 1'b0, 1'b0, 16'h77F0, 8'h20, 16'hC000);
    run_op("R9 zp rmw orig",         2'd2, 2'd2, 1'b0, 1'b0, 16'h0010, 8'h05, 16'hC000);
    run_op("R9 zp write enh",        2'd1, 2'd2, 1'b1, 1'b0, 16'h00FF, 8'hFF, 16'hC000);
    run_op("R10 dec extra enh",      2'd0, 2'd0, 1'b1, 1'b1, 16'h2000, 8'h01, 16'hD000);
    run_op("R10 dec no extra orig",  2'd0, 2'd0, 1'b0, 1'b1, 16'h2000, 8'h01, 16'hD000);
    run_op("R10 dec ignored on rmw", 2'd2, 2'd0, 1'b1, 1'b1, 16'h2000, 8'h01, 16'hD000);
    run_op("R10 dec zp enh",         2'd0, 2'd2, 1'b1, 1'b1, 16'h0033, 8'h44, 16'hD000);

    for (int n = 0; n < 60; n++) begin
      logic [1:0] rk, rm;
      rk = 2'($urandom % 3);
      rm = 2'($urandom % 3);
      run_op("R2/R4/R8/R9 random", rk, rm, 1'($urandom), 1'($urandom),
             16'($urandom), 8'($urandom), 16'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule